// File: doc/BRIEF.md
# Up/Down Rank and Turn-Restriction Unit

This per-router unit takes part in a distributed network reconfiguration pass. During the first broadcast of a pass, the router learns its rank: its hop distance from the broadcasting root. It reads this distance from the slot-cycle index in which the broadcast flag first reaches it over a live link. The root itself, recognised because the current broadcaster ID equals its own ID, takes rank zero. When the first broadcast ends, the unit combines its own rank with the ranks and IDs that its neighbours expose. From these it derives a registered turn-enable mask with one bit per input/output port pair. The mask forbids every turn from a link going down (toward higher rank) onto a link going up (toward lower rank). This makes every routing cycle impossible while the up-then-down path through the root keeps the network connected.

For the rest of the pass, the unit watches the flags of the other nodes' broadcasts. The first live port on which a broadcast arrives becomes the routing-table entry for that broadcaster, and the unit emits a single table write for it. A slot index of zero separates one broadcast from the next.

The controller has four states:
- ST_IDLE: no pass in progress.
- ST_RANK: first broadcast; rank capture.
- ST_XCHG: one cycle; mask load.
- ST_TABLE: remaining broadcasts; table writes.

The transitions are:
- pass_start from any state goes to ST_RANK.
- first_done goes from ST_RANK to ST_XCHG.
- ST_XCHG goes to ST_TABLE unconditionally.
- pass_end goes from ST_TABLE to ST_IDLE.

Top module: `updn_turn_unit`

## Requirements
- R1: After reset, my_rank is all ones (unranked), turn_en is all zeros and tbl_we is low.
- R2: One cycle after pass_start is sampled, my_rank is all ones and turn_en is all zeros.
- R3: In the ranking state, if bcast_src equals my_id while the unit is unranked, my_rank becomes 0 on the next cycle.
- R4: In the ranking state, while unranked, the first cycle with a flag on a live port sets my_rank to that cycle's slot_idx, visible on the next cycle.
- R5: A flag on a port whose link_alive bit is 0 never sets the rank and never causes a table write. Every mask bit whose input or output port is dead is 0.
- R6: Once ranked, my_rank does not change until the next pass_start.
- R7: Two cycles after first_done is sampled, turn_en bit (i*NPORT+o) is 1 exactly when i differs from o, both ports are alive, and neighbours i and o are not both above this node. Neighbour p is above when {nbr_rank[p], nbr_id[p]}, compared as one unsigned number, is less than {my_rank, my_id}. Neighbour fields sit at bit p*RANKW and p*IDW of the flat buses.
- R8: Between equal ranks, the lower node ID counts as above (closer to the root).
- R9: The U-turn bits (i == o) of turn_en are always 0.
- R10: In the table state, the first cycle of a broadcast with a flag on a live port gives one write on the next cycle: tbl_we high, tbl_dest = bcast_src, and tbl_port = the lowest-index live flagged port. Later arrivals give no write until a cycle with slot_idx = 0 starts a new broadcast. Arrivals at slot 0 are ignored.
- R11: No table write is made for the node's own broadcast (bcast_src == my_id).
- R12: After pass_end, flags cause no table write, and turn_en keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | IDW | This router's node ID |
| pass_start | input | 1 | Begin a reconfiguration pass |
| first_done | input | 1 | First broadcast has completed |
| pass_end | input | 1 | Reconfiguration pass has completed |
| bcast_src | input | IDW | ID of the node broadcasting now |
| slot_idx | input | RANKW | Hop-slot index inside the current broadcast |
| flag_in | input | NPORT | Broadcast flag arriving per port |
| link_alive | input | NPORT | Per-port link health |
| nbr_rank | input | NPORT*RANKW | Ranks exposed by neighbours |
| nbr_id | input | NPORT*IDW | IDs of neighbours |
| my_rank | output | RANKW | This router's rank, all ones when unranked |
| turn_en | output | NPORT*NPORT | Turn enable, bit i*NPORT+o |
| tbl_we | output | 1 | Routing-table write strobe |
| tbl_dest | output | IDW | Destination being written |
| tbl_port | output | PORTW | Output port for that destination |

## Verification
A wrong rank register shows up on my_rank one cycle after the flag that set it. It also skews turn_en two cycles after first_done, because the above/below test for every neighbour depends on the rank. A controller stuck in the wrong state appears at the ports in one of three ways: a mask that never loads, a mask that is not cleared one cycle after pass_start, or table writes that appear or vanish on the cycle after a flag. A stale first-arrival marker shows up as a missing or doubled tbl_we pulse within one cycle of the arrival.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RANK  = 2'd1,
        ST_XCHG  = 2'd2,
        ST_TABLE = 2'd3
    } phase_t;
endpackage

// File: rtl/rank_tracker.sv
module rank_tracker #(
    parameter int RANKW = 4,
    parameter int IDW   = 4,
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic [IDW-1:0]   my_id,
    input  logic [IDW-1:0]   bcast_src,
    input  logic [RANKW-1:0] slot_idx,
    input  logic [NPORT-1:0] arrive,
    output logic [RANKW-1:0] rank
);
    localparam logic [RANKW-1:0] UNRANKED = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rank <= UNRANKED;
        end else if (active && rank == UNRANKED) begin
            if (bcast_src == my_id)
                rank <= '0;
            else if (|arrive)
                rank <= slot_idx;
        end
    end
endmodule

// File: rtl/turn_mask_gen.sv
module turn_mask_gen #(
    parameter int NPORT = 4,
    parameter int RANKW = 4,
    parameter int IDW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   load,
    input  logic [RANKW-1:0]       my_rank,
    input  logic [IDW-1:0]         my_id,
    input  logic [NPORT-1:0]       link_alive,
    input  logic [NPORT*RANKW-1:0] nbr_rank,
    input  logic [NPORT*IDW-1:0]   nbr_id,
    output logic [NPORT*NPORT-1:0] turn_en
);
    localparam int KEYW = RANKW + IDW;

    logic [NPORT-1:0]       above;
    logic [NPORT*NPORT-1:0] mask_nxt;
    logic [KEYW-1:0]        self_key;

    assign self_key = {my_rank, my_id};

    for (genvar p = 0; p < NPORT; p++) begin : g_above
        assign above[p] = {nbr_rank[p*RANKW +: RANKW], nbr_id[p*IDW +: IDW]} < self_key;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        for (genvar o = 0; o < NPORT; o++) begin : g_out
            if (i == o) begin : g_uturn
                assign mask_nxt[i*NPORT+o] = 1'b0;
            end else begin : g_turn
                assign mask_nxt[i*NPORT+o] = link_alive[i] & link_alive[o]
                                           & ~(above[i] & above[o]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            turn_en <= '0;
        else if (load)
            turn_en <= mask_nxt;
    end
endmodule

// File: rtl/table_writer.sv
module table_writer #(
    parameter int NPORT = 4,
    parameter int RANKW = 4,
    parameter int IDW   = 4,
    parameter int PORTW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDW-1:0]   my_id,
    input  logic [IDW-1:0]   bcast_src,
    input  logic [RANKW-1:0] slot_idx,
    input  logic [NPORT-1:0] arrive,
    output logic             we,
    output logic [IDW-1:0]   dest,
    output logic [PORTW-1:0] port
);
    logic             seen;
    logic             hit;
    logic [PORTW-1:0] first_p;

    always_comb begin
        first_p = '0;
        for (int p = NPORT - 1; p >= 0; p--)
            if (arrive[p]) first_p = PORTW'(p);
    end

    assign hit = en && !seen && (|arrive) && (slot_idx != '0) && (bcast_src != my_id);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            we   <= 1'b0;
            dest <= '0;
            port <= '0;
        end else begin
            we <= hit;
            if (hit) begin
                dest <= bcast_src;
                port <= first_p;
            end
            if (slot_idx == '0)
                seen <= 1'b0;
            else if (hit)
                seen <= 1'b1;
        end
    end
endmodule

// File: rtl/updn_turn_unit.sv
module updn_turn_unit #(
    parameter int NNODE = 16,
    parameter int NPORT = 4,
    parameter int IDW   = $clog2(NNODE),
    parameter int RANKW = $clog2(NNODE),
    parameter int PORTW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDW-1:0]         my_id,
    input  logic                   pass_start,
    input  logic                   first_done,
    input  logic                   pass_end,
    input  logic [IDW-1:0]         bcast_src,
    input  logic [RANKW-1:0]       slot_idx,
    input  logic [NPORT-1:0]       flag_in,
    input  logic [NPORT-1:0]       link_alive,
    input  logic [NPORT*RANKW-1:0] nbr_rank,
    input  logic [NPORT*IDW-1:0]   nbr_id,
    output logic [RANKW-1:0]       my_rank,
    output logic [NPORT*NPORT-1:0] turn_en,
    output logic                   tbl_we,
    output logic [IDW-1:0]         tbl_dest,
    output logic [PORTW-1:0]       tbl_port
);
    import updn_pkg::*;

    phase_t           state, state_nxt;
    logic [NPORT-1:0] arrive;
    logic             rank_active, mask_load, tbl_en;

    assign arrive = flag_in & link_alive;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (pass_start) begin
            state_nxt = ST_RANK;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_RANK:  if (first_done) state_nxt = ST_XCHG;
                ST_XCHG:  state_nxt = ST_TABLE;
                ST_TABLE: if (pass_end) state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rank_active = (state == ST_RANK);
        mask_load   = (state == ST_XCHG);
        tbl_en      = (state == ST_TABLE);
    end

    rank_tracker #(.RANKW(RANKW), .IDW(IDW), .NPORT(NPORT)) u_rank (
        .clk(clk), .rst_n(rst_n), .clear(pass_start), .active(rank_active),
        .my_id(my_id), .bcast_src(bcast_src), .slot_idx(slot_idx),
        .arrive(arrive), .rank(my_rank)
    );

    turn_mask_gen #(.NPORT(NPORT), .RANKW(RANKW), .IDW(IDW)) u_mask (
        .clk(clk), .rst_n(rst_n), .clear(pass_start), .load(mask_load),
        .my_rank(my_rank), .my_id(my_id), .link_alive(link_alive),
        .nbr_rank(nbr_rank), .nbr_id(nbr_id), .turn_en(turn_en)
    );

    table_writer #(.NPORT(NPORT), .RANKW(RANKW), .IDW(IDW), .PORTW(PORTW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .en(tbl_en), .my_id(my_id),
        .bcast_src(bcast_src), .slot_idx(slot_idx), .arrive(arrive),
        .we(tbl_we), .dest(tbl_dest), .port(tbl_port)
    );
endmodule

// File: rtl/updn_turn_unit_chk.sv
module updn_turn_unit_chk #(
    parameter int NPORT = 4,
    parameter int IDW   = 4,
    parameter int RANKW = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pass_start,
    input logic [NPORT-1:0]       flag_in,
    input logic [NPORT-1:0]       link_alive,
    input logic [RANKW-1:0]       my_rank,
    input logic [NPORT*NPORT-1:0] turn_en,
    input logic                   tbl_we
);
    logic [NPORT*NPORT-1:0] diag;
    for (genvar p = 0; p < NPORT; p++) begin : g_diag
        for (genvar q = 0; q < NPORT; q++) begin : g_q
            assign diag[p*NPORT+q] = (p == q);
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start |=> (my_rank == '1 && turn_en == '0)); // R2
    AST_RANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (my_rank != '1 && !pass_start) |=> $stable(my_rank)); // R6
    AST_NO_UTURN: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_en & diag) == '0); // R9
    AST_WRITE_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> ($past(flag_in & link_alive) != '0)); // R5
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> !tbl_we); // R10
endmodule

bind updn_turn_unit updn_turn_unit_chk #(.NPORT(NPORT), .IDW(IDW), .RANKW(RANKW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .flag_in(flag_in),
    .link_alive(link_alive), .my_rank(my_rank), .turn_en(turn_en), .tbl_we(tbl_we)
);

// File: tb/sim_updn_turn_unit.sv
`timescale 1ns/1ps
module sim_updn_turn_unit;
    localparam int NPORT = 4;
    localparam int IDW   = 4;
    localparam int RANKW = 4;
    localparam int PORTW = 2;

    typedef struct packed {
        logic [3:0]  rank;
        logic [3:0]  alive;
        logic [1:0]  fport;
        logic [15:0] nrank;
        logic [15:0] nid;
        logic [15:0] mask;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{4'd2, 4'b1111, 2'd0, 16'h2231, 16'h7319, 16'h7ADA},
        '{4'd1, 4'b1011, 2'd0, 16'h1020, 16'h4280, 16'h2092},
        '{4'd3, 4'b1111, 2'd0, 16'h4444, 16'h4321, 16'h7BDE},
        '{4'd2, 4'b1111, 2'd0, 16'h2222, 16'h4916, 16'h5B5E},
        '{4'd2, 4'b0010, 2'd1, 16'h0000, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [IDW-1:0] my_id;
    logic pass_start, first_done, pass_end;
    logic [IDW-1:0] bcast_src;
    logic [RANKW-1:0] slot_idx;
    logic [NPORT-1:0] flag_in, link_alive;
    logic [NPORT*RANKW-1:0] nbr_rank;
    logic [NPORT*IDW-1:0] nbr_id;
    logic [RANKW-1:0] my_rank;
    logic [NPORT*NPORT-1:0] turn_en;
    logic tbl_we;
    logic [IDW-1:0] tbl_dest;
    logic [PORTW-1:0] tbl_port;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    updn_turn_unit #(.NNODE(16), .NPORT(NPORT)) u0 (
        .clk(clk), .rst_n(rst_n), .my_id(my_id), .pass_start(pass_start),
        .first_done(first_done), .pass_end(pass_end), .bcast_src(bcast_src),
        .slot_idx(slot_idx), .flag_in(flag_in), .link_alive(link_alive),
        .nbr_rank(nbr_rank), .nbr_id(nbr_id), .my_rank(my_rank),
        .turn_en(turn_en), .tbl_we(tbl_we), .tbl_dest(tbl_dest), .tbl_port(tbl_port)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_pass();
        pass_start = 1'b1;
        tick();
        pass_start = 1'b0;
    endtask

    task automatic finish_rank();
        first_done = 1'b1;
        tick();
        first_done = 1'b0;
        tick();
    endtask

    task automatic new_bcast(input logic [IDW-1:0] src);
        bcast_src = src;
        slot_idx  = '0;
        flag_in   = '0;
        tick();
    endtask

    task automatic arrive_at(input logic [RANKW-1:0] s, input logic [NPORT-1:0] f);
        slot_idx = s;
        flag_in  = f;
        tick();
        flag_in  = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; my_id = 4'd5; pass_start = 0; first_done = 0; pass_end = 0;
        bcast_src = 4'd0; slot_idx = '0; flag_in = '0; link_alive = '1;
        nbr_rank = '0; nbr_id = '0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 rank", 32'(my_rank), 32'hF);
        chk("R1 mask", 32'(turn_en), 32'h0);
        chk("R1 we", 32'(tbl_we), 32'h0);

        // vector walk: R2 R4 R6 R7 R8 R9 (expected masks hold 0 on all i==o bits)
        for (int v = 0; v < 5; v++) begin
            start_pass();
            chk("R2 rank cleared", 32'(my_rank), 32'hF);
            chk("R2 mask cleared", 32'(turn_en), 32'h0);
            link_alive = VECS[v].alive;
            arrive_at(VECS[v].rank, 4'(1 << VECS[v].fport));
            chk("R4 rank from slot", 32'(my_rank), 32'(VECS[v].rank));
            arrive_at(VECS[v].rank + 4'd1, 4'(1 << VECS[v].fport));
            chk("R6 rank held", 32'(my_rank), 32'(VECS[v].rank));
            nbr_rank = VECS[v].nrank;
            nbr_id   = VECS[v].nid;
            finish_rank();
            chk("R7 R8 R9 turn mask", 32'(turn_en), 32'(VECS[v].mask));
            pass_end = 1'b1;
            tick();
            pass_end = 1'b0;
        end

        // R3 root takes rank 0
        start_pass();
        bcast_src = 4'd5; slot_idx = '0;
        tick();
        chk("R3 root rank", 32'(my_rank), 32'h0);
        bcast_src = 4'd0;

        // R5 dead-link flag ignored for rank
        start_pass();
        link_alive = 4'b1110;
        arrive_at(4'd2, 4'b0001);
        chk("R5 dead flag no rank", 32'(my_rank), 32'hF);
        arrive_at(4'd3, 4'b0100);
        chk("R4 live flag rank", 32'(my_rank), 32'h3);
        arrive_at(4'd4, 4'b0010);
        chk("R6 later flag ignored", 32'(my_rank), 32'h3);
        nbr_rank = 16'h4444;
        nbr_id   = 16'h1234;
        finish_rank();
        chk("R5 dead port masked", 32'(turn_en), 32'h6AC0);

        // R10 table writes
        new_bcast(4'd9);
        chk("R10 no write at slot 0", 32'(tbl_we), 32'h0);
        arrive_at(4'd1, 4'b1100);
        chk("R10 write strobe", 32'(tbl_we), 32'h1);
        chk("R10 write dest", 32'(tbl_dest), 32'h9);
        chk("R10 lowest port", 32'(tbl_port), 32'h2);
        arrive_at(4'd2, 4'b0010);
        chk("R10 later arrival no write", 32'(tbl_we), 32'h0);

        new_bcast(4'd7);
        arrive_at(4'd1, 4'b0001);
        chk("R5 dead port no write", 32'(tbl_we), 32'h0);
        arrive_at(4'd2, 4'b0010);
        chk("R10 write after dead", 32'(tbl_we), 32'h1);
        chk("R10 dest 7", 32'(tbl_dest), 32'h7);
        chk("R10 port 1", 32'(tbl_port), 32'h1);

        // R11 own broadcast
        new_bcast(4'd5);
        arrive_at(4'd1, 4'b0010);
        chk("R11 own bcast no write", 32'(tbl_we), 32'h0);

        // R12 after pass_end
        pass_end = 1'b1;
        tick();
        pass_end = 1'b0;
        new_bcast(4'd9);
        arrive_at(4'd1, 4'b0010);
        chk("R12 idle no write", 32'(tbl_we), 32'h0);
        chk("R12 mask held", 32'(turn_en), 32'h6AC0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule